// File: doc/BRIEF.md
# Serial Coded-Stream Output Port

This block hands encoded stream bytes to an external receiver over a clocked serial link. A producer writes bytes into a small internal queue. The port raises a not-empty flag whenever it can deliver at least one more unit. The receiver pulls data by holding an active-low read enable.

In byte-lane mode each clock edge moves one whole byte onto the eight data pins. In single-pin mode each edge moves one bit onto the lowest data pin, most significant bit first. In single-pin mode the flag is judged at byte boundaries: once a byte has started, the flag stays high until its last bit has left. Both modes share the same timing.

The first unit appears on the edge that first samples the read enable low. Further units follow on every edge while the enable stays low and the flag is high. When the flag falls, the receiver is expected to keep the enable low for one more edge and then release it. Any edge that moves no data leaves the pins driving their previous value, and the unit-valid output marks such cycles as carrying no data.

Top module: `coded_stream_tx`

## Requirements
- R1: While reset is applied and on the first cycle after it, `nempty`, `unit_valid`, `wr_full` and `dout` are all zero.
- R2: A byte written into an empty port (`wr_en` high and `wr_full` low at an edge) makes `nempty` high after that same edge.
- R3: In byte-lane mode (`byte_mode` = 1), every edge that samples `rd_en_n` low while `nempty` is high puts the next byte, in write order, on `dout[7:0]` and sets `unit_valid` high after that edge. This repeats on consecutive edges without gaps.
- R4: In single-pin mode (`byte_mode` = 0), each such edge puts the next bit on `dout[0]`. Bytes are sent most significant bit first, one bit per edge, and `dout[7:1]` reads zero.
- R5: In single-pin mode, `nempty` stays high from the start of a byte until the edge that sends its last bit, whether or not the queue still holds bytes.
- R6: An edge that samples `rd_en_n` high moves no data: `unit_valid` is low after it and `dout` keeps its value. A stream paused mid-byte resumes with the next bit.
- R7: An edge that samples `rd_en_n` low while `nempty` is low sets `unit_valid` low and leaves `dout` unchanged. No byte is lost or repeated.
- R8: The queue holds `DEPTH` bytes (16 by default). `wr_full` is high while it is full, and writes made while full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects the byte lane, 0 selects single-pin output on dout[0]; changed only while idle |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | DATA_W | Byte written by the producer |
| wr_full | output | 1 | Queue holds DEPTH bytes |
| rd_en_n | input | 1 | Active-low read enable from the receiver |
| nempty | output | 1 | At least one more unit can be delivered |
| dout | output | DATA_W | Data lane; only bit 0 is used in single-pin mode |
| unit_valid | output | 1 | The unit on dout was moved by the last edge |

## Verification
The assertions assume that `byte_mode` changes only while no byte is partly sent and the read enable is high. The stimulus switches modes only after a full drain. The assertions also assume that the producer writes with no particular regard for the flag, so every write-while-full case must be dropped by the design. The bench writes past capacity only in byte-lane mode, from an empty queue, so that its own capacity model stays exact. The receiver side follows the release rule: after the flag falls, the enable is held low for exactly one more edge. Pauses are made both between bytes and in the middle of a byte.

// File: rtl/cst_pkg.sv
package cst_pkg;

   typedef enum logic {
      LANE_BIT  = 1'b0,
      LANE_BYTE = 1'b1
   } lane_mode_e;

endpackage

// File: rtl/cst_fifo.sv
module cst_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic              empty,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [DATA_W-1:0] store [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [CW-1:0]     fill;
   logic              do_push;
   logic              do_pop;

   assign empty    = (fill == '0);
   assign full     = (fill == CW'(DEPTH));
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign pop_data = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   // R8
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (fill == $past(fill)));

   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/cst_shifter.sv
module cst_shifter
   import cst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_mode_e        lane_mode,
   input  logic              take,
   input  logic              src_empty,
   input  logic [DATA_W-1:0] src_data,
   output logic              pop,
   output logic              busy,
   output logic [DATA_W-1:0] unit_q,
   output logic              unit_valid
);
   localparam int BW = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] shreg;
   logic [BW-1:0]     bits_left;
   logic              can_send;
   logic              at_boundary;

   assign busy        = (bits_left != '0);
   assign at_boundary = (lane_mode == LANE_BYTE) || !busy;
   assign can_send    = busy || !src_empty;
   assign pop         = take && !src_empty && at_boundary;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg      <= '0;
         bits_left  <= '0;
         unit_q     <= '0;
         unit_valid <= 1'b0;
      end else if (take && can_send) begin
         unit_valid <= 1'b1;
         if (lane_mode == LANE_BYTE) begin
            unit_q <= src_data;
         end else if (!busy) begin
            unit_q    <= {{(DATA_W-1){1'b0}}, src_data[DATA_W-1]};
            shreg     <= {src_data[DATA_W-2:0], 1'b0};
            bits_left <= BW'(DATA_W - 1);
         end else begin
            unit_q    <= {{(DATA_W-1){1'b0}}, shreg[DATA_W-1]};
            shreg     <= {shreg[DATA_W-2:0], 1'b0};
            bits_left <= bits_left - BW'(1);
         end
      end else begin
         unit_valid <= 1'b0;
      end
   end

   // R5
   mid_byte_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_mode == LANE_BIT && busy) |-> !pop);

endmodule

// File: rtl/coded_stream_tx.sv
module coded_stream_tx
   import cst_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_en_n,
   output logic              nempty,
   output logic [DATA_W-1:0] dout,
   output logic              unit_valid
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("coded_stream_tx: DATA_W must be at least 2");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("coded_stream_tx: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   lane_mode_e        lane_mode;
   logic              fifo_empty;
   logic              fifo_pop;
   logic [DATA_W-1:0] fifo_data;
   logic              sh_busy;
   logic [DATA_W-1:0] unit_q;

   assign lane_mode = byte_mode ? LANE_BYTE : LANE_BIT;
   assign nempty    = sh_busy || !fifo_empty;

   cst_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (fifo_pop),
      .pop_data  (fifo_data),
      .empty     (fifo_empty),
      .full      (wr_full)
   );

   cst_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_mode  (lane_mode),
      .take       (!rd_en_n),
      .src_empty  (fifo_empty),
      .src_data   (fifo_data),
      .pop        (fifo_pop),
      .busy       (sh_busy),
      .unit_q     (unit_q),
      .unit_valid (unit_valid)
   );

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_lane
         if (i == 0) begin : g_pin0
            assign dout[i] = unit_q[i];
         end else begin : g_upper
            assign dout[i] = (lane_mode == LANE_BYTE) ? unit_q[i] : 1'b0;
         end
      end
   endgenerate

   // R2
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_full) |=> nempty);

   // R3
   valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_valid |-> $past(!rd_en_n && nempty));

   // R6
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_n |=> !unit_valid);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en_n && !nempty) |=>
         (!unit_valid && (byte_mode != $past(byte_mode) || $stable(dout))));

endmodule

// File: tb/tb_coded_stream_tx.sv
module tb_coded_stream_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int DEPTH      = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              byte_mode = 1'b1;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_full;
   logic              rd_en_n = 1'b1;
   logic              nempty;
   logic [DATA_W-1:0] dout;
   logic              unit_valid;

   int                n_checks = 0;
   int                n_fail   = 0;
   bit                done     = 1'b0;
   logic [DATA_W-1:0] exp_q[$];
   int                bit_idx  = 0;
   logic [DATA_W-1:0] prev_dout = '0;
   logic              prev_mode = 1'b1;
   bit                mon_on   = 1'b0;

   coded_stream_tx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
      .wr_data(wr_data), .wr_full(wr_full), .rd_en_n(rd_en_n),
      .nempty(nempty), .dout(dout), .unit_valid(unit_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_on && !done) begin
         if (unit_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected unit", int'(dout), 0);
            end else if (byte_mode) begin
               chk(dout == exp_q[0], "R3 byte order", int'(dout), int'(exp_q[0]));
               void'(exp_q.pop_front());
            end else begin
               chk(dout[0] == exp_q[0][DATA_W-1-bit_idx], "R4 bit order msb first",
                   int'(dout[0]), int'(exp_q[0][DATA_W-1-bit_idx]));
               chk(dout[DATA_W-1:1] == '0, "R4 upper pins zero",
                   int'(dout[DATA_W-1:1]), 0);
               bit_idx++;
               if (bit_idx == DATA_W) begin
                  bit_idx = 0;
                  void'(exp_q.pop_front());
               end
            end
         end else if (byte_mode == prev_mode) begin
            chk(dout == prev_dout, "R6/R7 pins hold when idle", int'(dout), int'(prev_dout));
         end
         prev_dout = dout;
         prev_mode = byte_mode;
      end
   end

   // driver: one write, expected item queued per the capacity rule
   task automatic put(input logic [DATA_W-1:0] b);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = b;
      if (exp_q.size() < DEPTH) exp_q.push_back(b);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drain(output int got);
      got = 0;
      @(negedge clk);
      rd_en_n = 1'b0;
      forever begin
         @(negedge clk);
         if (unit_valid) got++;
         if (!nempty) break;
      end
      @(negedge clk);
      chk(unit_valid == 1'b0, "R7 unit after flag drop invalid", int'(unit_valid), 0);
      rd_en_n = 1'b1;
      @(negedge clk);
      chk(unit_valid == 1'b0, "R6 stopped after release", int'(unit_valid), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int got;
      repeat (3) @(negedge clk);
      chk(nempty == 1'b0 && unit_valid == 1'b0 && wr_full == 1'b0 && dout == '0,
          "R1 reset state", {nempty, unit_valid, wr_full, dout}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(nempty == 1'b0 && unit_valid == 1'b0 && dout == '0,
          "R1 after reset", {nempty, unit_valid, dout}, 0);
      mon_on = 1'b1;

      // byte-lane basic stream
      put(8'hA1);
      chk(nempty == 1'b1, "R2 flag rises after write", int'(nempty), 1);
      put(8'h5B);
      put(8'h00);
      drain(got);
      chk(got == 3, "R3 continuous byte count", got, 3);
      chk(nempty == 1'b0, "R7 flag low after drain", int'(nempty), 0);

      // pause between bytes
      put(8'h11); put(8'h22); put(8'h33); put(8'h44);
      @(negedge clk); rd_en_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rd_en_n = 1'b1;
      @(negedge clk);
      chk(unit_valid == 1'b0, "R6 pause no unit", int'(unit_valid), 0);
      @(negedge clk);
      chk(nempty == 1'b1, "R6 data kept during pause", int'(nempty), 1);
      drain(got);
      chk(got == 2, "R6 resumed remaining bytes", got, 2);

      // single-pin mode, flag on byte boundaries
      byte_mode = 1'b0;
      put(8'hA5); put(8'h3C);
      @(negedge clk); rd_en_n = 1'b0;
      for (int k = 1; k <= 2*DATA_W; k++) begin
         @(negedge clk);
         if (k == 12) chk(nempty == 1'b1, "R5 flag high mid final byte", int'(nempty), 1);
         if (k == 2*DATA_W) chk(nempty == 1'b0, "R5 flag low after last bit", int'(nempty), 0);
      end
      @(negedge clk);
      chk(unit_valid == 1'b0, "R7 bit unit after flag drop", int'(unit_valid), 0);
      rd_en_n = 1'b1;
      @(negedge clk);

      // single-pin pause mid-byte
      put(8'h96);
      @(negedge clk); rd_en_n = 1'b0;
      repeat (3) @(negedge clk);
      rd_en_n = 1'b1;
      @(negedge clk);
      chk(unit_valid == 1'b0, "R6 mid-byte pause", int'(unit_valid), 0);
      chk(nempty == 1'b1, "R5 flag held mid-byte", int'(nempty), 1);
      @(negedge clk);
      drain(got);
      chk(got == 5, "R6 resumed remaining bits", got, 5);

      // capacity
      byte_mode = 1'b1;
      @(negedge clk);
      for (int k = 0; k < DEPTH + 2; k++) put(8'(8'hC0 + k));
      chk(wr_full == 1'b1, "R8 full flag", int'(wr_full), 1);
      drain(got);
      chk(got == DEPTH, "R8 extra writes dropped", got, DEPTH);
      chk(wr_full == 1'b0, "R8 full clears", int'(wr_full), 0);

      chk(exp_q.size() == 0, "R3 all items delivered", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule